// File: doc/BRIEF.md
# Scalar Compare and Bit-Test Execute Unit

This unit executes one 32-bit scalar-compare instruction word per clock cycle. The operand values for both source fields arrive already fetched, each up to 64 bits wide. A generation-select input chooses between the older and the newer instruction set.

The unit owns four pieces of architectural state:
- a one-bit condition code;
- a vector-skip flag;
- a 32-bit mode register, of which only the indexing-enable bit (bit 27) is written here;
- a 32-bit M0 register.

The word decodes to one of these operations:
- signed or unsigned 32-bit relational compares;
- single-bit tests on a 32-bit or 64-bit operand;
- 64-bit equality and inequality compares;
- a vector-skip control;
- an indexing-enable operation that merges fields into M0.

A word that cannot be executed raises a one-cycle illegal flag and leaves all state as it was.

The instruction word layout is as follows:
- bits 31:23 must hold 9'b101111110;
- bits 22:16 are the 7-bit opcode;
- bits 15:8 are source field 1, which also serves as an 8-bit immediate;
- bits 7:0 are source field 0.

Updates happen on the rising edge of `clk` in a cycle where `valid_i` is high. The illegal flag is registered, so it appears in the cycle that follows the offending word.

Top module: `scmp_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears the condition code, the vector-skip flag, the mode register, M0 and the illegal flag to zero.
- R2: Opcodes 0..5 compare opnd0[31:0] against opnd1[31:0] as signed values, in the order EQ, NE, GT, GE, LT, LE. The condition code becomes 1 when the relation holds and 0 when it does not.
- R3: Opcodes 6..11 perform the same six relations, in the same order, on unsigned 32-bit values.
- R4: Opcodes 12 and 13 test bit opnd1[4:0] of opnd0[31:0]. Opcode 12 sets the condition code to 1 when that bit is clear; opcode 13 sets it to 1 when that bit is set.
- R5: Opcodes 14 and 15 perform the same clear and set tests on the 64-bit opnd0, using opnd1[5:0] as the bit index.
- R6: Opcode 16 loads the vector-skip flag with bit opnd1[4:0] of opnd0 and leaves the condition code unchanged.
- R7: Opcode 17 (newer generation only) does the following:
  - sets mode bit 27;
  - writes M0 as (M0 & 32'hFFFF0F00) | (instr[11:8] << 12) | opnd0[7:0];
  - leaves the condition code and the vector-skip flag unchanged.
- R8: With the newer generation selected, opcode 18 sets the condition code to (opnd0 == opnd1) over 64 bits, and opcode 19 sets it to (opnd0 != opnd1).
- R9: A valid word whose bits 31:23 differ from 9'b101111110 raises illegal_o in the next cycle only and changes no state.
- R10: A valid word with an opcode above 19 raises illegal_o and changes no state.
- R11: With newgen_i = 0 (older generation), opcodes 17, 18 and 19 raise illegal_o and change no state.
- R12: While valid_i is low, no state changes and illegal_o is low in the following cycle.
- R13: Opcodes 0..15, 18 and 19 leave the vector-skip flag, the mode register and M0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| opnd0_i | input | 64 | Fetched value for source field 0 |
| opnd1_i | input | 64 | Fetched value for source field 1 |
| newgen_i | input | 1 | 1 selects the newer generation |
| cc_o | output | 1 | Condition code |
| vskip_o | output | 1 | Vector-skip flag |
| mode_o | output | 32 | Mode register |
| m0_o | output | 32 | M0 register |
| illegal_o | output | 1 | One-cycle pulse for a rejected word |

## Verification
The compares are driven with the following operand patterns, each chosen to separate one pair of behaviours:
- Equal operands separate the strict relations from the non-strict ones.
- Operands that straddle the sign bit (32'h80000000 against 1) separate signed from unsigned ordering.
- 64-bit operands that differ only in their upper half show whether the equality compares look at all 64 bits.

Bit tests use indices above 31 on the 32-bit form, to show that the index is masked, and index 63 on the 64-bit form. The M0 merge is tried over a preloaded M0 so that lost or leaked fields become visible. Bad format tags, opcodes above 19 and newer-only opcodes under the older generation are mixed into constrained random sequences, so that any state touched by a rejected word is caught.

// File: rtl/scmp_pkg.sv
`timescale 1ns/1ps
package scmp_pkg;

    localparam int          INSTR_W      = 32;
    localparam int          OPC_W        = 7;
    localparam logic [8:0]  FMT_TAG      = 9'b101111110;
    localparam int          IDX_EN_BIT   = 27;
    localparam logic [31:0] M0_KEEP_MASK = 32'hFFFF0F00;
    localparam int          MAX_OPC      = 19;
    localparam int          FIRST_NEW    = 17;

    typedef struct packed {
        logic [8:0]       tag;
        logic [OPC_W-1:0] opcode;
        logic [7:0]       fld1;
        logic [7:0]       fld0;
    } instr_t;

    typedef enum logic [2:0] {
        CLS_CMP32S,
        CLS_CMP32U,
        CLS_BIT32,
        CLS_BIT64,
        CLS_VSKIP,
        CLS_IDXON,
        CLS_CMP64,
        CLS_BAD
    } op_cls_e;

    typedef enum logic [2:0] {
        REL_EQ,
        REL_NE,
        REL_GT,
        REL_GE,
        REL_LT,
        REL_LE
    } rel_e;

    typedef struct packed {
        op_cls_e cls;
        rel_e    rel;
        logic    want_set;
    } dec_t;

    // Relation lookup from a less-than and an equal result.
    function automatic logic rel_eval(rel_e r, logic lt, logic eq);
        case (r)
            REL_EQ:  return eq;
            REL_NE:  return !eq;
            REL_GT:  return !lt && !eq;
            REL_GE:  return !lt;
            REL_LT:  return lt;
            default: return lt || eq;
        endcase
    endfunction

    function automatic dec_t decode_op(logic [OPC_W-1:0] op, logic newgen);
        dec_t d;
        d.want_set = 1'b0;
        d.rel      = REL_EQ;
        d.cls      = CLS_BAD;
        if (op <= 7'd5) begin
            d.cls = CLS_CMP32S;
            d.rel = rel_e'(op[2:0]);
        end else if (op <= 7'd11) begin
            d.cls = CLS_CMP32U;
            d.rel = rel_e'(3'(op - 7'd6));
        end else if (op <= 7'd13) begin
            d.cls      = CLS_BIT32;
            d.want_set = op[0];
        end else if (op <= 7'd15) begin
            d.cls      = CLS_BIT64;
            d.want_set = op[0];
        end else if (op == 7'd16) begin
            d.cls = CLS_VSKIP;
        end else if (newgen && op == 7'd17) begin
            d.cls = CLS_IDXON;
        end else if (newgen && op <= 7'(MAX_OPC)) begin
            d.cls = CLS_CMP64;
            d.rel = op[0] ? REL_NE : REL_EQ;
        end
        return d;
    endfunction

endpackage

// File: rtl/scmp_decode.sv
`timescale 1ns/1ps
module scmp_decode
    import scmp_pkg::*;
(
    input  instr_t iw,
    input  logic   newgen,
    output dec_t   dec,
    output logic   illegal
);
    dec_t d_op;

    always_comb begin
        d_op    = decode_op(iw.opcode, newgen);
        dec     = d_op;
        illegal = (iw.tag != FMT_TAG) || (d_op.cls == CLS_BAD);
    end
endmodule

// File: rtl/scmp_eval.sv
`timescale 1ns/1ps
module scmp_eval
    import scmp_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DWORD_W = 64
) (
    input  dec_t               dec,
    input  logic [DWORD_W-1:0] a,
    input  logic [DWORD_W-1:0] b,
    input  logic [7:0]         imm8,
    input  logic [WORD_W-1:0]  m0_cur,
    output logic               cc_we,
    output logic               cc_val,
    output logic               vskip_we,
    output logic               vskip_val,
    output logic               idx_we,
    output logic [WORD_W-1:0]  m0_next
);
    localparam int SH32 = $clog2(WORD_W);
    localparam int SH64 = $clog2(DWORD_W);

    // One less-than result per signedness; the signed form flips the sign bit.
    logic [1:0] lt32;
    logic       eq32, eq64, bit32, bit64;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_sign
            logic [WORD_W-1:0] flip;
            assign flip    = (g == 0) ? {1'b1, {(WORD_W-1){1'b0}}} : '0;
            assign lt32[g] = (a[WORD_W-1:0] ^ flip) < (b[WORD_W-1:0] ^ flip);
        end
    endgenerate

    assign eq32  = a[WORD_W-1:0] == b[WORD_W-1:0];
    assign eq64  = a == b;
    assign bit32 = a[b[SH32-1:0]];
    assign bit64 = a[b[SH64-1:0]];

    always_comb begin
        cc_we     = 1'b0;
        cc_val    = 1'b0;
        vskip_we  = 1'b0;
        vskip_val = bit32;
        idx_we    = 1'b0;
        m0_next   = (m0_cur & M0_KEEP_MASK) | (WORD_W'(imm8[3:0]) << 12)
                  | WORD_W'(a[7:0]);
        case (dec.cls)
            CLS_CMP32S: begin cc_we = 1'b1; cc_val = rel_eval(dec.rel, lt32[0], eq32); end
            CLS_CMP32U: begin cc_we = 1'b1; cc_val = rel_eval(dec.rel, lt32[1], eq32); end
            CLS_BIT32:  begin cc_we = 1'b1; cc_val = dec.want_set ? bit32 : !bit32; end
            CLS_BIT64:  begin cc_we = 1'b1; cc_val = dec.want_set ? bit64 : !bit64; end
            CLS_CMP64:  begin cc_we = 1'b1; cc_val = rel_eval(dec.rel, 1'b0, eq64); end
            CLS_VSKIP:  vskip_we = 1'b1;
            CLS_IDXON:  idx_we = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/scmp_state.sv
`timescale 1ns/1ps
module scmp_state
    import scmp_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              illegal,
    input  logic              cc_we,
    input  logic              cc_val,
    input  logic              vskip_we,
    input  logic              vskip_val,
    input  logic              idx_we,
    input  logic [WORD_W-1:0] m0_next,
    output logic              cc_q,
    output logic              vskip_q,
    output logic [WORD_W-1:0] mode_q,
    output logic [WORD_W-1:0] m0_q,
    output logic              illegal_q
);
    logic commit;
    assign commit = valid && !illegal;

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q      <= 1'b0;
            vskip_q   <= 1'b0;
            mode_q    <= '0;
            m0_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= valid && illegal;
            if (commit && cc_we)    cc_q    <= cc_val;
            if (commit && vskip_we) vskip_q <= vskip_val;
            if (commit && idx_we) begin
                mode_q[IDX_EN_BIT] <= 1'b1;
                m0_q               <= m0_next;
            end
        end
    end
endmodule

// File: rtl/scmp_exec_unit.sv
`timescale 1ns/1ps
module scmp_exec_unit
    import scmp_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int DWORD_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DWORD_W-1:0] opnd0_i,
    input  logic [DWORD_W-1:0] opnd1_i,
    input  logic               newgen_i,
    output logic               cc_o,
    output logic               vskip_o,
    output logic [WORD_W-1:0]  mode_o,
    output logic [WORD_W-1:0]  m0_o,
    output logic               illegal_o
);
    instr_t            iw;
    dec_t              dec;
    logic              illegal;
    logic              cc_we, cc_val, vskip_we, vskip_val, idx_we;
    logic [WORD_W-1:0] m0_next;

    assign iw = instr_t'(instr_i);

    scmp_decode u_dec (
        .iw      (iw),
        .newgen  (newgen_i),
        .dec     (dec),
        .illegal (illegal)
    );

    scmp_eval #(.WORD_W(WORD_W), .DWORD_W(DWORD_W)) u_eval (
        .dec       (dec),
        .a         (opnd0_i),
        .b         (opnd1_i),
        .imm8      (iw.fld1),
        .m0_cur    (m0_o),
        .cc_we     (cc_we),
        .cc_val    (cc_val),
        .vskip_we  (vskip_we),
        .vskip_val (vskip_val),
        .idx_we    (idx_we),
        .m0_next   (m0_next)
    );

    scmp_state #(.WORD_W(WORD_W)) u_state (
        .clk       (clk),
        .rst       (rst),
        .valid     (valid_i),
        .illegal   (illegal),
        .cc_we     (cc_we),
        .cc_val    (cc_val),
        .vskip_we  (vskip_we),
        .vskip_val (vskip_val),
        .idx_we    (idx_we),
        .m0_next   (m0_next),
        .cc_q      (cc_o),
        .vskip_q   (vskip_o),
        .mode_q    (mode_o),
        .m0_q      (m0_o),
        .illegal_q (illegal_o)
    );
endmodule

// File: rtl/scmp_exec_chk.sv
`timescale 1ns/1ps
module scmp_exec_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [31:0]       instr_i,
    input logic              newgen_i,
    input logic              cc_o,
    input logic              vskip_o,
    input logic [WORD_W-1:0] mode_o,
    input logic [WORD_W-1:0] m0_o,
    input logic              illegal_o
);
    logic [6:0] opc;
    assign opc = instr_i[22:16];

    assert_reject_keeps_state_R9: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> ($stable(cc_o) && $stable(vskip_o) && $stable(mode_o) && $stable(m0_o)));

    assert_idle_no_change_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(valid_i) |-> (!illegal_o && $stable(cc_o) && $stable(vskip_o)
                             && $stable(mode_o) && $stable(m0_o)));

    assert_oldgen_reject_R11: assert property (@(posedge clk) disable iff (rst)
        $past(valid_i && !newgen_i && opc >= 7'd17 && opc <= 7'd19) |-> illegal_o);

    assert_high_opcode_reject_R10: assert property (@(posedge clk) disable iff (rst)
        $past(valid_i && opc > 7'd19) |-> illegal_o);

    assert_vskip_keeps_cc_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_i) && $past(opc) == 7'd16) |-> $stable(cc_o));

    assert_cmp_side_effects_R13: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_i) && $past(opc) < 7'd16) |->
            ($stable(vskip_o) && $stable(mode_o) && $stable(m0_o)));

    assert_merge_fields_R7: assert property (@(posedge clk) disable iff (rst)
        (m0_o[31:16] == 16'h0) && (m0_o[11:8] == 4'h0)
        && ((mode_o & ~(32'h1 << 27)) == 32'h0));
endmodule

bind scmp_exec_unit scmp_exec_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .newgen_i  (newgen_i),
    .cc_o      (cc_o),
    .vskip_o   (vskip_o),
    .mode_o    (mode_o),
    .m0_o      (m0_o),
    .illegal_o (illegal_o)
);

// File: tb/tb_scmp_exec_unit.sv
`timescale 1ns/1ps
module tb_scmp_exec_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [63:0] opnd0_i = '0;
    logic [63:0] opnd1_i = '0;
    logic        newgen_i = 1'b1;
    logic        cc_o, vskip_o, illegal_o;
    logic [31:0] mode_o, m0_o;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic        m_cc = 1'b0, m_vs = 1'b0;
    logic [31:0] m_mode = '0, m_m0 = '0;

    always #2.5 clk = ~clk;

    scmp_exec_unit dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
        .opnd0_i(opnd0_i), .opnd1_i(opnd1_i), .newgen_i(newgen_i),
        .cc_o(cc_o), .vskip_o(vskip_o), .mode_o(mode_o), .m0_o(m0_o),
        .illegal_o(illegal_o)
    );

    function automatic logic [31:0] mk(input logic [8:0] tag, input int op, input logic [7:0] f1, input logic [7:0] f0);
        return {tag, 7'(op), f1, f0};
    endfunction

    function automatic string tag_for(input int op, input logic good, input logic ng);
        if (!good)                          return "R9";
        if (op > 19)                        return "R10";
        if (!ng && op >= 17)                return "R11";
        if (op <= 5)                        return "R2";
        if (op <= 11)                       return "R3";
        if (op <= 13)                       return "R4";
        if (op <= 15)                       return "R5";
        if (op == 16)                       return "R6";
        if (op == 17)                       return "R7";
        return "R8";
    endfunction

    function automatic logic rel_ref(input int r, input longint x, input longint y);
        case (r)
            0: return x == y;
            1: return x != y;
            2: return x > y;
            3: return x >= y;
            4: return x < y;
            default: return x <= y;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic run(input logic v, input logic [31:0] ins, input logic [63:0] a,
                       input logic [63:0] b, input logic ng);
        int    op;
        logic  good, bad;
        string t, side;
        op   = int'(ins[22:16]);
        good = (ins[31:23] == 9'b101111110);
        bad  = !good || op > 19 || (!ng && op >= 17);
        t    = v ? tag_for(op, good, ng) : "R12";
        side = (v && !bad && (op <= 15 || op >= 18)) ? "R13" : t;
        valid_i = v; instr_i = ins; opnd0_i = a; opnd1_i = b; newgen_i = ng;
        @(negedge clk);
        if (v && !bad) begin
            if (op <= 5)
                m_cc = rel_ref(op, longint'($signed(a[31:0])), longint'($signed(b[31:0])));
            else if (op <= 11)
                m_cc = rel_ref(op - 6, longint'({32'h0, a[31:0]}), longint'({32'h0, b[31:0]}));
            else if (op <= 13)
                m_cc = (a[b[4:0]] == op[0]);
            else if (op <= 15)
                m_cc = (a[b[5:0]] == op[0]);
            else if (op == 16)
                m_vs = a[b[4:0]];
            else if (op == 17) begin
                m_mode = m_mode | 32'h0800_0000;
                m_m0   = (m_m0 & 32'hFFFF0F00) | {16'h0, ins[11:8], 12'h0} | {24'h0, a[7:0]};
            end else
                m_cc = (op == 18) ? (a == b) : (a != b);
        end
        chk(t,    "illegal", {31'h0, illegal_o}, {31'h0, v && bad});
        chk((op == 16 || op == 17) && v && !bad ? t : (bad ? t : t), "cc", {31'h0, cc_o}, {31'h0, m_cc});
        chk(side, "vskip", {31'h0, vskip_o}, {31'h0, m_vs});
        chk(side, "mode",  mode_o, m_mode);
        chk(side, "m0",    m0_o,   m_m0);
    endtask

    function automatic logic [63:0] pick_val();
        case ($urandom % 6)
            0: return 64'h0;
            1: return {$urandom, $urandom};
            2: return {32'h0, 32'h8000_0000 ^ 32'($urandom % 4)};
            3: return 64'hFFFF_FFFF_FFFF_FFFF;
            4: return 64'($urandom % 8);
            default: return {$urandom, 32'h7FFF_FFFF};
        endcase
    endfunction

    localparam logic [8:0] TAG = 9'b101111110;

    initial begin
        logic [63:0] a, b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "cc",      {31'h0, cc_o}, 32'h0);
        chk("R1", "vskip",   {31'h0, vskip_o}, 32'h0);
        chk("R1", "mode",    mode_o, 32'h0);
        chk("R1", "m0",      m0_o, 32'h0);
        chk("R1", "illegal", {31'h0, illegal_o}, 32'h0);

        // R2/R3: sign-bit straddle separates signed from unsigned
        run(1, mk(TAG, 2, 8'h01, 8'h00), 64'h8000_0000, 64'h1, 1);
        run(1, mk(TAG, 8, 8'h01, 8'h00), 64'h8000_0000, 64'h1, 1);
        run(1, mk(TAG, 4, 8'h01, 8'h00), 64'h8000_0000, 64'h1, 1);
        run(1, mk(TAG, 10, 8'h01, 8'h00), 64'h8000_0000, 64'h1, 1);
        // equal operands: strict vs non-strict
        run(1, mk(TAG, 3, 8'h01, 8'h00), 64'h55, 64'h55, 1);
        run(1, mk(TAG, 2, 8'h01, 8'h00), 64'h55, 64'h55, 1);
        run(1, mk(TAG, 11, 8'h01, 8'h00), 64'h55, 64'h55, 1);
        // R4: index 37 masks to 5
        run(1, mk(TAG, 13, 8'h01, 8'h00), 64'h20, 64'd37, 1);
        run(1, mk(TAG, 12, 8'h01, 8'h00), 64'h20, 64'd37, 1);
        // R5: bit 63
        run(1, mk(TAG, 15, 8'h01, 8'h00), 64'h8000_0000_0000_0000, 64'd63, 1);
        run(1, mk(TAG, 14, 8'h01, 8'h00), 64'h8000_0000_0000_0000, 64'd63, 1);
        // R6: vskip set then clear, cc held
        run(1, mk(TAG, 16, 8'h01, 8'h00), 64'h4, 64'd34, 1);
        run(1, mk(TAG, 16, 8'h01, 8'h00), 64'h4, 64'd3, 1);
        // R7: merge twice over preloaded M0
        run(1, mk(TAG, 17, 8'hA5, 8'h00), 64'h3C, 64'h0, 1);
        run(1, mk(TAG, 17, 8'h07, 8'h00), 64'hFFFF_FFC1, 64'h0, 1);
        // R8: upper half differs only
        run(1, mk(TAG, 18, 8'h01, 8'h00), 64'h1_0000_0000, 64'h0, 1);
        run(1, mk(TAG, 19, 8'h01, 8'h00), 64'h1_0000_0000, 64'h0, 1);
        run(1, mk(TAG, 18, 8'h01, 8'h00), 64'hDEAD_0000_0000_BEEF, 64'hDEAD_0000_0000_BEEF, 1);
        // R9, R10, R11 rejects
        run(1, mk(9'h17F, 0, 8'h01, 8'h00), 64'h5, 64'h5, 1);
        run(1, mk(TAG, 20, 8'h01, 8'h00), 64'h5, 64'h5, 1);
        run(1, mk(TAG, 127, 8'h01, 8'h00), 64'h5, 64'h5, 1);
        run(1, mk(TAG, 17, 8'hFF, 8'h00), 64'hFF, 64'h0, 0);
        run(1, mk(TAG, 18, 8'h01, 8'h00), 64'h5, 64'h5, 0);
        // R12: valid low with a word that would change state
        run(0, mk(TAG, 16, 8'h01, 8'h00), 64'h0, 64'h0, 1);
        run(0, mk(TAG, 0, 8'h01, 8'h00), 64'h7, 64'h7, 1);

        for (int i = 0; i < 3000; i++) begin
            int          op;
            logic [8:0]  tg;
            a  = pick_val();
            b  = ($urandom % 4 == 0) ? a : pick_val();
            op = ($urandom % 10 == 0) ? int'($urandom % 128) : int'($urandom % 20);
            tg = ($urandom % 12 == 0) ? 9'($urandom) : TAG;
            run(($urandom % 8) != 0, mk(tg, op, 8'($urandom), 8'($urandom)), a, b,
                ($urandom % 4) != 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule